// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Detector

This block watches a serial stream of single bits and flags every place where the four most recent accepted bits, ending with the bit being presented now, read 0110 or 1001 (oldest bit first). The flag is a Mealy output. It is raised in the same cycle as the fourth bit of the match, while that bit is still on the input, and it depends on both the stored state and that bit. History is kept across detections, so matches may share bits and nothing is cleared after a hit.

A bit is accepted only in cycles where its valid strobe is high. Other cycles leave the history untouched. The history is held in a minimized state machine with seven states: one start state and six states for the longest suffix of the history that is also a prefix of either pattern (0, 1, 01, 10, 011, 100). All histories that lead to the same future outputs share one state. An active-low synchronous reset returns the machine to its start state.

Top module: `dual_pattern_detector`

## Requirements
- R1: A rising clock edge with rst_n low puts the machine in its start state, and in the following cycle match_out is 0 whatever bit_in and bit_valid are.
- R2: The first three accepted bits after a reset never raise match_out. Bits accepted before the reset are never combined with bits accepted after it.
- R3: match_out is 1 in the cycle where bit_valid is high and the accepted bits, with bit_in last, end in 0 1 1 0.
- R4: match_out is 1 in the cycle where bit_valid is high and the accepted bits, with bit_in last, end in 1 0 0 1.
- R5: Detections overlap and nothing is reset after a hit. The stream 0110110 flags its 4th and 7th bits, and the stream 1001001 flags its 4th and 7th bits.
- R6: The output is Mealy. With the same stored history, bit_in 0 and bit_in 1 in the same cycle give different match_out values where a pattern completes on one of them.
- R7: While bit_valid is low, match_out is 0 and the stored history does not change.
- R8: Starting from reset, the stream 0011011100101011001100101 gives match_out 0000100000100000101010100, one bit per accepted cycle.
- R9: For any stream of accepted bits, match_out equals a reference model built on a four-bit shift register with a fill count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | High when bit_in carries a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit |
| match_out | output | 1 | High while the presented bit completes 0110 or 1001 |

## Verification
The assertions assume that bit_valid and bit_in are stable and known around each rising edge. They also assume that rst_n is held low for at least one edge before any stream starts, so the shadow history they compare against begins empty. The bench changes its inputs only on falling edges. It pulses reset before each directed sequence and mixes random valid gaps into the long random streams. This keeps the stimulus within those assumptions while still exercising hold cycles between accepted bits.

// File: rtl/seqdet_pkg.sv
// Package: shared state encoding for the dual-pattern detector.
// Assumes: a 3-bit binary encoding is enough for the seven reduced states.
package seqdet_pkg;
    localparam int STATE_W = 3;
    localparam int PAT_LEN = 4;
    localparam int HIST_W  = PAT_LEN - 1;

    // Each state names the longest suffix of history that begins a pattern.
    typedef enum logic [STATE_W-1:0] {
        ST_START = 3'd0,
        ST_Z     = 3'd1,   // ends in 0
        ST_O     = 3'd2,   // ends in 1
        ST_ZO    = 3'd3,   // ends in 01
        ST_OZ    = 3'd4,   // ends in 10
        ST_ZOO   = 3'd5,   // ends in 011
        ST_OZZ   = 3'd6    // ends in 100
    } det_state_t;
endpackage

// File: rtl/seqdet_next_state.sv
// Module: next-state function of the reduced detector machine.
// Assumes: called only for accepted bits; hold is handled by the register.
module seqdet_next_state
    import seqdet_pkg::*;
(
    input  det_state_t cur_state,
    input  logic       din,
    output det_state_t nxt_state
);
    // Transition table of the minimized machine.
    always_comb begin
        unique case (cur_state)
            ST_START: nxt_state = din ? ST_O   : ST_Z;
            ST_Z:     nxt_state = din ? ST_ZO  : ST_Z;
            ST_O:     nxt_state = din ? ST_O   : ST_OZ;
            ST_ZO:    nxt_state = din ? ST_ZOO : ST_OZ;
            ST_OZ:    nxt_state = din ? ST_ZO  : ST_OZZ;
            ST_ZOO:   nxt_state = din ? ST_O   : ST_OZ;
            ST_OZZ:   nxt_state = din ? ST_ZO  : ST_Z;
            default:  nxt_state = ST_START;
        endcase
    end
endmodule

// File: rtl/seqdet_match_logic.sv
// Module: Mealy output decode of the detector.
// Assumes: cur_state is the registered state; din is the bit on the wire now.
module seqdet_match_logic
    import seqdet_pkg::*;
(
    input  det_state_t cur_state,
    input  logic       din,
    input  logic       din_valid,
    output logic       hit
);
    // A hit needs an accepted bit that completes either pattern.
    always_comb begin
        hit = 1'b0;
        if (din_valid) begin
            if (cur_state == ST_ZOO && !din) hit = 1'b1;
            if (cur_state == ST_OZZ &&  din) hit = 1'b1;
        end
    end
endmodule

// File: rtl/seqdet_state_reg.sv
// Module: state register with synchronous active-low reset and hold.
// Assumes: the next state is valid whenever load is high.
module seqdet_state_reg
    import seqdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  det_state_t nxt_state,
    output det_state_t state_q
);
    // Register update: reset wins, then load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= ST_START;
        else if (load) state_q <= nxt_state;
    end

    // R1: a reset edge leaves the start state behind it.
    p_reset_start_r1: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_START));

    // R7: no accepted bit, no state change.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(state_q));
endmodule

// File: rtl/dual_pattern_detector.sv
// Module: top of the overlapping 0110 / 1001 Mealy detector.
// Assumes: inputs are synchronous to clk; reset is applied before use.
module dual_pattern_detector
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic match_out
);
    det_state_t state_q;
    det_state_t state_d;

    seqdet_next_state u_next (
        .cur_state (state_q),
        .din       (bit_in),
        .nxt_state (state_d)
    );

    seqdet_state_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (bit_valid),
        .nxt_state (state_d),
        .state_q   (state_q)
    );

    seqdet_match_logic u_out (
        .cur_state (state_q),
        .din       (bit_in),
        .din_valid (bit_valid),
        .hit       (match_out)
    );

    // Shadow shift-register history used only by the checks below.
    logic [HIST_W-1:0] sh_hist;
    logic [1:0]        sh_fill;

    // Shadow model update: shift on accepted bits, count up to full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hist <= '0;
            sh_fill <= '0;
        end else if (bit_valid) begin
            sh_hist <= {sh_hist[HIST_W-2:0], bit_in};
            if (sh_fill != 2'd3) sh_fill <= sh_fill + 2'd1;
        end
    end

    logic [PAT_LEN-1:0] sh_window;
    assign sh_window = {sh_hist, bit_in};

    // R9: reduced machine agrees with the shift-register view (covers R3, R4, R5).
    p_model_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_out == (bit_valid && sh_fill == 2'd3 &&
                      (sh_window == 4'b0110 || sh_window == 4'b1001)));

    // R2: fewer than three prior accepted bits cannot complete a pattern.
    p_early_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_fill != 2'd3) |-> !match_out);

    // R7: output stays low without an accepted bit.
    p_quiet_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> !match_out);
endmodule

// File: tb/dual_pattern_detector_tb_top.sv
`timescale 1ns/1ps
module dual_pattern_detector_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic match_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pattern_detector dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .match_out (match_out)
    );

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Bench reference history: last three accepted bits and a fill count.
    logic [2:0] ref_hist = 3'b000;
    int         ref_fill = 0;

    function automatic logic ref_step(logic rst, logic v, logic b);
        logic e;
        e = 1'b0;
        if (!rst) begin
            ref_fill = 0;
            ref_hist = 3'b000;
        end else if (v) begin
            e = (ref_fill >= 3) && ({ref_hist, b} == 4'b0110 || {ref_hist, b} == 4'b1001);
            ref_hist = {ref_hist[1:0], b};
            if (ref_fill < 3) ref_fill++;
        end
        return e;
    endfunction

    // Driver: present one cycle of stimulus and queue its expected output.
    task automatic drive(logic rst, logic v, logic b, string tag);
        logic e;
        @(negedge clk);
        rst_n = rst; bit_valid = v; bit_in = b;
        e = ref_step(rst, v, b);
        sb_q.push_back('{exp: e, tag: tag});
    endtask

    // Driver variant with a literal expected value (stated trace).
    task automatic drive_lit(logic b, logic lit, string tag);
        logic e;
        @(negedge clk);
        rst_n = 1'b1; bit_valid = 1'b1; bit_in = b;
        e = ref_step(1'b1, 1'b1, b);
        sb_q.push_back('{exp: lit, tag: tag});
    endtask

    // One reset cycle followed by a checked reset-state cycle.
    task automatic do_reset();
        drive(1'b0, 1'b0, 1'b0, "R1");
        drive(1'b0, 1'b1, 1'b1, "R1");
    endtask

    task automatic drive_str(logic [31:0] bits, int n, string tag);
        for (int i = n - 1; i >= 0; i--) drive(1'b1, 1'b1, bits[i], tag);
    endtask

    // Monitor: compare each queued item a quarter period after the drive.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (match_out !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: match_out=%b expected=%b at %0t", it.tag, match_out, it.exp, $time);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [24:0] tx;
        logic [24:0] tz;
        tx = 25'b0011011100101011001100101;
        tz = 25'b0000100000100000101010100;

        // R1 reset state.
        repeat (2) drive(1'b0, 1'b0, 1'b0, "R1");
        do_reset();

        // R8 stated trace with literal expected values.
        for (int i = 24; i >= 0; i--) drive_lit(tx[i], tz[i], "R8");

        // R3 and R4 basic patterns.
        do_reset(); drive_str(32'b0110, 4, "R3");
        do_reset(); drive_str(32'b1001, 4, "R4");

        // R5 overlapping detections.
        do_reset(); drive_str(32'b0110110, 7, "R5");
        do_reset(); drive_str(32'b1001001, 7, "R5");
        do_reset(); drive_str(32'b011001, 6, "R5");

        // R6 Mealy: same history, bit decides the output this cycle.
        do_reset(); drive_str(32'b011, 3, "R6"); drive(1'b1, 1'b1, 1'b1, "R6");
        do_reset(); drive_str(32'b011, 3, "R6"); drive(1'b1, 1'b1, 1'b0, "R6");

        // R7 invalid cycles hold history and keep output low.
        do_reset(); drive_str(32'b011, 3, "R7");
        repeat (4) drive(1'b1, 1'b0, 1'b0, "R7");
        drive(1'b1, 1'b0, 1'b1, "R7");
        drive(1'b1, 1'b1, 1'b0, "R7");

        // R2 reset mid-stream discards earlier bits; early bits stay quiet.
        do_reset(); drive_str(32'b011, 3, "R2");
        do_reset(); drive_str(32'b0, 1, "R2");
        drive_str(32'b100, 3, "R2");
        do_reset(); drive_str(32'b100, 3, "R2"); drive(1'b1, 1'b1, 1'b1, "R2");

        // R9 long random streams with random valid gaps.
        for (int s = 0; s < 4; s++) begin
            do_reset();
            for (int k = 0; k < 1500; k++) begin
                logic v;
                logic b;
                v = ($urandom_range(0, 3) != 0);
                b = $urandom_range(0, 1);
                drive(1'b1, v, b, "R9");
            end
        end

        // Drain the scoreboard.
        drive(1'b1, 1'b0, 1'b0, "R7");
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule